// File: doc/BRIEF.md
# Sticky Interrupt Status and DMA Halt Unit

This block gathers single-cycle event pulses from the transmit path, the receive path and the DMA engine. It holds them in an 8-bit sticky status field. Software reads that field and clears individual bits by writing ones to them. The same 32-bit status word also carries live, read-only copies of the receive and transmit read pointers and the head-of-queue sequence number. It also carries a multicast hash bit, which is captured while receive DMA runs.

A second register, the DMA control word, holds four enables and a 5-bit receive depth. The transmit enable and the receive enable gate the interrupt line. A receive-threshold event is raised every cycle in which the receive FIFO entry count differs from the programmed depth. Three of the events are fatal. While any fatal status bit is set, a halt output is high and both DMA run outputs are forced low. The block has no bus protocol: a write strobe selects one of the two registers, and the read data follows the select input combinationally.

Top module: `irq_status_unit`

## Requirements
- R1: After reset the status bits 7:0 read 0, the control word reads 0, the multicast bit reads 0, and `irq` and `dma_halt` are low.
- R2: A pulse on an event input sets its status bit at the next clock edge, and the bit stays set after the pulse ends. The bit positions are: tx-empty 0, tx-sent 1, link-fail 2, mem-err 3, tx-abort 4, rx-underflow 6, rx-overflow 7.
- R3: A status write (`wr_status`) clears every bit 7:0 whose `wdata` bit is 1. Bits written with 0 keep their value, and with no write the bits keep their value.
- R4: If an event sets a bit in the same cycle as a write clears it, the bit is set after the edge.
- R5: Status bit 5 is set at each edge where the `rx_count` input differs from the depth field (control bits 8:4). While they are equal, the threshold event does not set the bit.
- R6: `irq` is high when bits 1:0 have any bit set and control bit 0 is 1, or when bit 5 is set and control bit 9 is 1, or when any error bit (2, 3, 4, 6, 7) is set, whatever the enables.
- R7: `dma_halt` is high exactly while any of status bits 3, 4, 7 is set. `tx_dma_run` equals control bit 1 and `rx_dma_run` equals control bit 15, each forced low while `dma_halt` is high.
- R8: With `rd_sel`=0, read bits 11:8 equal `rx_rd_ptr`, bits 24:16 equal `tx_rd_ptr` and bits 29:25 equal `head_seq`, all in the same cycle. Bits 15:12 and 31 read 0.
- R9: Read bit 30 takes the value of `mcast_hash` at each edge while control bit 15 is 1, and holds its value otherwise.
- R10: A control write (`wr_ctrl`) stores only bits 0, 1, 4 to 9 and 15. With `rd_sel`=1 the read returns those bits and 0 elsewhere.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_status | input | 1 | Write-one-to-clear strobe for status bits 7:0 |
| wr_ctrl | input | 1 | Write strobe for the control word |
| wdata | input | 32 | Write data |
| rd_sel | input | 1 | Read select: 0 status word, 1 control word |
| rdata | output | 32 | Read data |
| ev_tx_empty | input | 1 | Transmit ring empty pulse |
| ev_tx_sent | input | 1 | Frame with interrupt request sent pulse |
| ev_link_fail | input | 1 | Link failure pulse |
| ev_mem_err | input | 1 | DMA memory error pulse (fatal) |
| ev_tx_abort | input | 1 | Transmit abort pulse (fatal) |
| ev_rx_underflow | input | 1 | Receive frame could not be queued pulse |
| ev_rx_overflow | input | 1 | Receive DMA FIFO overflow pulse (fatal) |
| rx_count | input | 5 | Receive FIFO entry count |
| rx_rd_ptr | input | 4 | Receive read pointer |
| tx_rd_ptr | input | 9 | Transmit read pointer |
| head_seq | input | 5 | Sequence number of frame at queue head |
| mcast_hash | input | 1 | Multicast hash select result |
| irq | output | 1 | Interrupt line |
| dma_halt | output | 1 | High while a fatal status bit is set |
| tx_dma_run | output | 1 | Transmit DMA enable after halt gating |
| rx_dma_run | output | 1 | Receive DMA enable after halt gating |

## Verification
The assertions assume that each event input is a single-cycle pulse, and that software writes never target both registers in the same cycle. The bench drives every pulse for exactly one clock and issues one write at a time. The pointer, sequence and hash inputs may change freely. The properties only relate them to the read word through registered state, so the bench changes them between cycles at the falling edge. The bench keeps `rx_count` equal to the programmed depth outside the threshold scenario, so bit 5 only appears where a check expects it.

// File: rtl/irq_status_pkg.sv
package irq_status_pkg;
  localparam int unsigned EV_W    = 8;
  localparam int unsigned DATA_W  = 32;
  localparam int unsigned DEPTH_W = 5;
  localparam int unsigned RXP_W   = 4;
  localparam int unsigned TXP_W   = 9;
  localparam int unsigned SEQ_W   = 5;

  localparam int unsigned B_TX_EMPTY = 0;
  localparam int unsigned B_TX_SENT  = 1;
  localparam int unsigned B_LINK     = 2;
  localparam int unsigned B_MEM      = 3;
  localparam int unsigned B_ABORT    = 4;
  localparam int unsigned B_THRESH   = 5;
  localparam int unsigned B_UNDER    = 6;
  localparam int unsigned B_OVER     = 7;

  localparam logic [EV_W-1:0] TX_GRP_MASK = 8'b0000_0011;
  localparam logic [EV_W-1:0] RX_GRP_MASK = 8'b0010_0000;
  localparam logic [EV_W-1:0] ERR_MASK    = 8'b1101_1100;
  localparam logic [EV_W-1:0] FATAL_MASK  = 8'b1001_1000;

  localparam int unsigned C_TX_IE  = 0;
  localparam int unsigned C_TX_EN  = 1;
  localparam int unsigned C_DEPTH  = 4;
  localparam int unsigned C_RX_IE  = 9;
  localparam int unsigned C_RX_EN  = 15;
  localparam logic [DATA_W-1:0] CTRL_MASK = 32'h0000_83F3;

  localparam int unsigned F_RXP  = 8;
  localparam int unsigned F_TXP  = 16;
  localparam int unsigned F_SEQ  = 25;
  localparam int unsigned F_HASH = 30;

  // sticky update: new events win over a clearing write
  function automatic logic [EV_W-1:0] w1c_next(input logic [EV_W-1:0] cur,
                                               input logic [EV_W-1:0] set,
                                               input logic [EV_W-1:0] clr);
    return set | (cur & ~clr);
  endfunction

  function automatic logic [DATA_W-1:0] pack_status(input logic [EV_W-1:0] st,
                                                    input logic [RXP_W-1:0] rxp,
                                                    input logic [TXP_W-1:0] txp,
                                                    input logic [SEQ_W-1:0] seq,
                                                    input logic hash);
    logic [DATA_W-1:0] w;
    w = '0;
    w[EV_W-1:0] = st;
    w[F_RXP +: RXP_W] = rxp;
    w[F_TXP +: TXP_W] = txp;
    w[F_SEQ +: SEQ_W] = seq;
    w[F_HASH] = hash;
    return w;
  endfunction
endpackage

// File: rtl/irq_sticky_bank.sv
module irq_sticky_bank
  import irq_status_pkg::*;
#(
  parameter int unsigned N = EV_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_vec,
  input  logic [N-1:0] clr_vec,
  output logic [N-1:0] status_q
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic b_q;
    always_ff @(posedge clk) begin
      if (!rst_n) b_q <= 1'b0;
      else        b_q <= set_vec[i] | (b_q & ~clr_vec[i]);
    end
    assign status_q[i] = b_q;
  end
endmodule

// File: rtl/irq_ctrl_reg.sv
module irq_ctrl_reg
  import irq_status_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_ctrl,
  input  logic [DATA_W-1:0]  wdata,
  output logic [DATA_W-1:0]  ctrl_q,
  output logic               tx_ie,
  output logic               tx_en,
  output logic               rx_ie,
  output logic               rx_en,
  output logic [DEPTH_W-1:0] depth
);
  always_ff @(posedge clk) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (wr_ctrl) ctrl_q <= wdata & CTRL_MASK;
  end
  assign tx_ie = ctrl_q[C_TX_IE];
  assign tx_en = ctrl_q[C_TX_EN];
  assign rx_ie = ctrl_q[C_RX_IE];
  assign rx_en = ctrl_q[C_RX_EN];
  assign depth = ctrl_q[C_DEPTH +: DEPTH_W];
endmodule

// File: rtl/irq_readback.sv
module irq_readback
  import irq_status_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_en,
  input  logic              mcast_hash,
  input  logic              rd_sel,
  input  logic [EV_W-1:0]   status_q,
  input  logic [DATA_W-1:0] ctrl_q,
  input  logic [RXP_W-1:0]  rx_rd_ptr,
  input  logic [TXP_W-1:0]  tx_rd_ptr,
  input  logic [SEQ_W-1:0]  head_seq,
  output logic              hash_q,
  output logic [DATA_W-1:0] rdata
);
  always_ff @(posedge clk) begin
    if (!rst_n)     hash_q <= 1'b0;
    else if (rx_en) hash_q <= mcast_hash;
  end

  always_comb begin
    if (rd_sel) rdata = ctrl_q;
    else        rdata = pack_status(status_q, rx_rd_ptr, tx_rd_ptr, head_seq, hash_q);
  end
endmodule

// File: rtl/irq_status_unit.sv
module irq_status_unit
  import irq_status_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_status,
  input  logic        wr_ctrl,
  input  logic [31:0] wdata,
  input  logic        rd_sel,
  output logic [31:0] rdata,
  input  logic        ev_tx_empty,
  input  logic        ev_tx_sent,
  input  logic        ev_link_fail,
  input  logic        ev_mem_err,
  input  logic        ev_tx_abort,
  input  logic        ev_rx_underflow,
  input  logic        ev_rx_overflow,
  input  logic [4:0]  rx_count,
  input  logic [3:0]  rx_rd_ptr,
  input  logic [8:0]  tx_rd_ptr,
  input  logic [4:0]  head_seq,
  input  logic        mcast_hash,
  output logic        irq,
  output logic        dma_halt,
  output logic        tx_dma_run,
  output logic        rx_dma_run
);
  logic [DATA_W-1:0]  ctrl_q;
  logic               tx_ie, tx_en, rx_ie, rx_en;
  logic [DEPTH_W-1:0] depth;
  logic               thresh_evt;
  logic [EV_W-1:0]    set_vec;
  logic [EV_W-1:0]    clr_vec;
  logic [EV_W-1:0]    status_q;
  logic               hash_q;
  logic               fatal_any;

  irq_ctrl_reg u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_ctrl(wr_ctrl), .wdata(wdata),
    .ctrl_q(ctrl_q), .tx_ie(tx_ie), .tx_en(tx_en), .rx_ie(rx_ie),
    .rx_en(rx_en), .depth(depth)
  );

  assign thresh_evt = (rx_count != depth);

  always_comb begin
    set_vec             = '0;
    set_vec[B_TX_EMPTY] = ev_tx_empty;
    set_vec[B_TX_SENT]  = ev_tx_sent;
    set_vec[B_LINK]     = ev_link_fail;
    set_vec[B_MEM]      = ev_mem_err;
    set_vec[B_ABORT]    = ev_tx_abort;
    set_vec[B_THRESH]   = thresh_evt;
    set_vec[B_UNDER]    = ev_rx_underflow;
    set_vec[B_OVER]     = ev_rx_overflow;
  end

  assign clr_vec = wr_status ? wdata[EV_W-1:0] : '0;

  irq_sticky_bank #(.N(EV_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .clr_vec(clr_vec),
    .status_q(status_q)
  );

  irq_readback u_rb (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .mcast_hash(mcast_hash),
    .rd_sel(rd_sel), .status_q(status_q), .ctrl_q(ctrl_q),
    .rx_rd_ptr(rx_rd_ptr), .tx_rd_ptr(tx_rd_ptr), .head_seq(head_seq),
    .hash_q(hash_q), .rdata(rdata)
  );

  assign fatal_any  = |(status_q & FATAL_MASK);
  assign dma_halt   = fatal_any;
  assign tx_dma_run = tx_en & ~fatal_any;
  assign rx_dma_run = rx_en & ~fatal_any;
  assign irq = (tx_ie & |(status_q & TX_GRP_MASK))
             | (rx_ie & |(status_q & RX_GRP_MASK))
             | (|(status_q & ERR_MASK));
endmodule

// File: rtl/irq_status_chk.sv
module irq_status_chk
  import irq_status_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [EV_W-1:0]   set_vec,
  input logic [EV_W-1:0]   clr_vec,
  input logic [EV_W-1:0]   status_q,
  input logic              dma_halt,
  input logic              tx_dma_run,
  input logic              rx_dma_run,
  input logic              irq,
  input logic              tx_ie,
  input logic              rx_ie,
  input logic              rd_sel,
  input logic [DATA_W-1:0] rdata
);
  // R2 R4
  event_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_vec) |=> ((status_q & $past(set_vec)) == $past(set_vec)));

  // R3
  w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr_vec & ~set_vec)) |=> ((status_q & $past(clr_vec & ~set_vec)) == '0));

  // R3
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((status_q ^ $past(status_q)) & ~$past(set_vec | clr_vec)) == '0));

  // R7
  halt_blocks_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dma_halt |-> (!tx_dma_run && !rx_dma_run));

  // R7
  halt_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dma_halt) |-> $past(|(set_vec & FATAL_MASK)));

  // R6
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_ie && !rx_ie && ((status_q & ERR_MASK) == '0)) |-> !irq);

  // R8
  zero_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_sel |-> (rdata[15:12] == 4'h0 && !rdata[31]));
endmodule

bind irq_status_unit irq_status_chk u_chk (
  .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .clr_vec(clr_vec),
  .status_q(status_q), .dma_halt(dma_halt), .tx_dma_run(tx_dma_run),
  .rx_dma_run(rx_dma_run), .irq(irq), .tx_ie(tx_ie), .rx_ie(rx_ie),
  .rd_sel(rd_sel), .rdata(rdata)
);

// File: tb/tb_irq_status_unit.sv
`timescale 1ns/1ps
module tb_irq_status_unit;
  logic clk = 1'b0;
  logic rst_n;
  logic wr_status, wr_ctrl, rd_sel;
  logic [31:0] wdata, rdata;
  logic ev_tx_empty, ev_tx_sent, ev_link_fail, ev_mem_err, ev_tx_abort;
  logic ev_rx_underflow, ev_rx_overflow;
  logic [4:0] rx_count, head_seq;
  logic [3:0] rx_rd_ptr;
  logic [8:0] tx_rd_ptr;
  logic mcast_hash;
  logic irq, dma_halt, tx_dma_run, rx_dma_run;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  irq_status_unit dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr_st(input logic [31:0] v);
    wr_status = 1'b1; wdata = v; step(); wr_status = 1'b0; wdata = '0;
  endtask

  task automatic wr_cr(input logic [31:0] v);
    wr_ctrl = 1'b1; wdata = v; step(); wr_ctrl = 1'b0; wdata = '0;
  endtask

  function automatic logic [7:0] st_bits();
    return rdata[7:0];
  endfunction

  task automatic rd_status(output logic [31:0] v);
    rd_sel = 1'b0; #1; v = rdata;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd_status(v);
    chk("R1 status", v, 32'h0);
    rd_sel = 1'b1; #1;
    chk("R1 ctrl", rdata, 32'h0);
    rd_sel = 1'b0;
    chk("R1 irq", {31'b0, irq}, 32'h0);
    chk("R1 halt", {31'b0, dma_halt}, 32'h0);
  endtask

  task automatic t_sticky();
    logic [31:0] v;
    ev_tx_empty = 1; step(); ev_tx_empty = 0;
    ev_tx_sent = 1; step(); ev_tx_sent = 0;
    ev_link_fail = 1; step(); ev_link_fail = 0;
    ev_rx_underflow = 1; step(); ev_rx_underflow = 0;
    step(); step();
    rd_status(v);
    chk("R2 sticky bits", {24'b0, v[7:0]}, 32'h47);
    wr_st(32'hFF);
    rd_status(v);
    chk("R2 cleared", {24'b0, v[7:0]}, 32'h0);
  endtask

  task automatic t_w1c();
    logic [31:0] v;
    ev_tx_empty = 1; ev_tx_sent = 1; ev_link_fail = 1; step();
    ev_tx_empty = 0; ev_tx_sent = 0; ev_link_fail = 0;
    wr_st(32'h0);
    rd_status(v);
    chk("R3 zero write", {24'b0, v[7:0]}, 32'h07);
    wr_st(32'hFFFF_FF02);
    rd_status(v);
    chk("R3 clear bit1", {24'b0, v[7:0]}, 32'h05);
    wr_st(32'h05);
    rd_status(v);
    chk("R3 clear rest", {24'b0, v[7:0]}, 32'h0);
  endtask

  task automatic t_collide();
    logic [31:0] v;
    ev_tx_empty = 1; wr_status = 1; wdata = 32'h01; step();
    ev_tx_empty = 0; wr_status = 0; wdata = '0;
    rd_status(v);
    chk("R4 event wins", {24'b0, v[7:0]}, 32'h01);
    wr_st(32'h01);
    rd_status(v);
    chk("R4 later clear", {24'b0, v[7:0]}, 32'h0);
  endtask

  task automatic t_thresh();
    logic [31:0] v;
    wr_cr(32'h0000_0030);   // depth 3
    rx_count = 5'd3; step(); wr_st(32'h20);
    rd_status(v);
    chk("R5 equal no event", {24'b0, v[7:0]}, 32'h0);
    rx_count = 5'd5; step();
    rd_status(v);
    chk("R5 differ sets", {24'b0, v[7:0]}, 32'h20);
    wr_st(32'h20);
    rd_status(v);
    chk("R5 persists", {24'b0, v[7:0]}, 32'h20);
    rx_count = 5'd3; step(); wr_st(32'h20);
    rd_status(v);
    chk("R5 cleared", {24'b0, v[7:0]}, 32'h0);
  endtask

  task automatic t_irq();
    // depth stays 3, rx_count 3
    ev_tx_sent = 1; step(); ev_tx_sent = 0;
    chk("R6 tx masked", {31'b0, irq}, 32'h0);
    wr_cr(32'h0000_0031);
    chk("R6 tx enabled", {31'b0, irq}, 32'h1);
    wr_st(32'h02);
    chk("R6 tx cleared", {31'b0, irq}, 32'h0);
    rx_count = 5'd1; step(); rx_count = 5'd3;
    chk("R6 rx masked", {31'b0, irq}, 32'h0);
    wr_cr(32'h0000_0231);
    chk("R6 rx enabled", {31'b0, irq}, 32'h1);
    wr_st(32'h20);
    wr_cr(32'h0000_0030);
    ev_link_fail = 1; step(); ev_link_fail = 0;
    chk("R6 error ungated", {31'b0, irq}, 32'h1);
    wr_st(32'h04);
    chk("R6 error cleared", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_fatal();
    wr_cr(32'h0000_8032);
    chk("R7 runs", {30'b0, tx_dma_run, rx_dma_run}, 32'h3);
    ev_rx_underflow = 1; step(); ev_rx_underflow = 0;
    chk("R7 underflow not fatal", {31'b0, dma_halt}, 32'h0);
    wr_st(32'h40);
    ev_mem_err = 1; ev_rx_overflow = 1; step();
    ev_mem_err = 0; ev_rx_overflow = 0;
    chk("R7 halt", {29'b0, dma_halt, tx_dma_run, rx_dma_run}, 32'h4);
    wr_st(32'h08);
    chk("R7 halt holds", {31'b0, dma_halt}, 32'h1);
    wr_st(32'h80);
    chk("R7 halt released", {29'b0, dma_halt, tx_dma_run, rx_dma_run}, 32'h3);
    ev_tx_abort = 1; step(); ev_tx_abort = 0;
    chk("R7 abort halts", {31'b0, dma_halt}, 32'h1);
    wr_st(32'h10);
    chk("R7 abort cleared", {31'b0, dma_halt}, 32'h0);
  endtask

  task automatic t_alias();
    logic [31:0] v;
    rx_rd_ptr = 4'hA; tx_rd_ptr = 9'h1B5; head_seq = 5'h13; #1;
    rd_status(v);
    chk("R8 rx ptr", {28'b0, v[11:8]}, 32'hA);
    chk("R8 tx ptr", {23'b0, v[24:16]}, 32'h1B5);
    chk("R8 seq", {27'b0, v[29:25]}, 32'h13);
    chk("R8 zeros", {27'b0, v[31], v[15:12]}, 32'h0);
  endtask

  task automatic t_hash();
    logic [31:0] v;
    // ctrl has rx dma enabled from t_fatal
    mcast_hash = 1; step();
    rd_status(v);
    chk("R9 latched", {31'b0, v[30]}, 32'h1);
    wr_cr(32'h0000_0030);
    mcast_hash = 0; step(); step();
    rd_status(v);
    chk("R9 held", {31'b0, v[30]}, 32'h1);
    wr_cr(32'h0000_8030);
    step();
    rd_status(v);
    chk("R9 follows again", {31'b0, v[30]}, 32'h0);
  endtask

  task automatic t_ctrl();
    wr_cr(32'hFFFF_FFFF);
    rd_sel = 1'b1; #1;
    chk("R10 ctrl mask", rdata, 32'h0000_83F3);
    rd_sel = 1'b0;
    wr_cr(32'h0000_0030);
    wr_st(32'hFF);
    wr_cr(32'h0000_0000);
    rd_sel = 1'b1; #1;
    chk("R10 ctrl zero", rdata, 32'h0);
    rd_sel = 1'b0;
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 0; wr_status = 0; wr_ctrl = 0; wdata = '0; rd_sel = 0;
    ev_tx_empty = 0; ev_tx_sent = 0; ev_link_fail = 0; ev_mem_err = 0;
    ev_tx_abort = 0; ev_rx_underflow = 0; ev_rx_overflow = 0;
    rx_count = '0; rx_rd_ptr = '0; tx_rd_ptr = '0; head_seq = '0; mcast_hash = 0;
    @(negedge clk); step(); step();
    rst_n = 1;
    t_reset();
    t_sticky();
    t_w1c();
    t_collide();
    t_thresh();
    t_irq();
    t_fatal();
    t_alias();
    t_hash();
    t_ctrl();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule